// File: doc/BRIEF.md
# Serial Command Port for a Voice Recorder Sequencer

This block is the host-facing serial port of a voice record/playback engine. A microcontroller, acting as SPI master, sends 24-bit command frames. Each frame holds a 16-bit row address followed by an 8-bit control code, and both are sent least significant bit first. While the command bits shift in on MOSI, the port shifts a status word out on MISO in the same frame. That status word is captured from the row sequencer when the frame opens. One frame can therefore read status and start a new operation at the same time.

The three SPI pins are oversampled in the system clock domain through a synchronizer chain. Every pin event reaches the outputs on the third rising clock edge after the pin changes. Opening a frame (SS falling) sends a one-cycle interrupt-clear pulse to the sequencer. Closing a frame (SS rising) sends a one-cycle execute strobe together with the captured code, the captured address and a decoded command kind, but only if exactly 24 SCLK rising edges were seen. The command outputs cannot exert back-pressure, because an SPI master cannot be stalled in the middle of a frame. The sequencer must accept each strobe in the cycle it appears. SCLK must stay at least four clock periods per phase.

Top module: `spi_cmd_port`

## Requirements
- R1: A frame opens on the falling edge of spi_ss_n and restarts the bit count. SCLK edges while spi_ss_n is high are ignored: no strobe, no MISO drive, and the command fields are unchanged.
- R2: At frame open, a 24-bit status word is captured with bit 0 = seq_ovf, bit 1 = seq_eom, bits 17:2 = seq_row and bits 23:18 = 0. Bit 0 appears on spi_miso at frame open, and each SCLK falling edge inside the frame advances to the next bit. After bit 23 the line reads 0.
- R3: int_clr pulses high for exactly one clock at every frame open.
- R4: MOSI is sampled on SCLK rising edges. The first 16 bits form cmd_addr and the next 8 bits form cmd_code, each least significant bit first. cmd_code and cmd_addr change only together with cmd_exec.
- R5: cmd_exec pulses for exactly one clock on the rising edge of spi_ss_n when exactly 24 bits were received.
- R6: A frame with fewer or more than 24 bits produces no cmd_exec and leaves cmd_code, cmd_addr and cmd_kind unchanged.
- R7: spi_miso_oe is high from frame open to frame close and low otherwise. spi_miso is 0 while it is low.
- R8: cmd_kind decodes cmd_code as follows: 0x10 gives 1 (play), 0x20 gives 2 (record), 0x30 gives 3 (fast-forward), 0x40 gives 4 (stop), 0x50 gives 5 (read status only), and any other code gives 0.
- R9: Every output reacts to a pin change on the third rising clock edge after the change.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial command data in |
| seq_eom | input | 1 | End-of-message flag from the sequencer |
| seq_ovf | input | 1 | Overflow flag from the sequencer |
| seq_row | input | 16 | Current row address from the sequencer |
| spi_miso | output | 1 | Serial status data out |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| cmd_exec | output | 1 | One-cycle execute strobe |
| cmd_code | output | 8 | Captured control code |
| cmd_addr | output | 16 | Captured row address |
| cmd_kind | output | 3 | Decoded command kind |
| int_clr | output | 1 | One-cycle interrupt-clear pulse |

## Verification
The assertions check, on every cycle, that both strobes last a single clock and that the command fields never move without an execute strobe. They also check how the strobes line up with the MISO drive window: the clear pulse falls inside it, and the execute strobe comes just as it closes. Only the bench's scenarios can show the rest. These are the bit order of the captured fields and of the status word, the rejection of short and long frames, the command decode, the inertness of SCLK outside a frame, and the exact three-edge latency. The bench checks them with a per-clock reference model and with per-frame checks.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_PLAY = 3'd1,
    KIND_REC  = 3'd2,
    KIND_FFWD = 3'd3,
    KIND_STOP = 3'd4,
    KIND_STAT = 3'd5
  } cmd_kind_e;

  function automatic cmd_kind_e decode_kind(input logic [7:0] code);
    case (code)
      8'h10:   return KIND_PLAY;
      8'h20:   return KIND_REC;
      8'h30:   return KIND_FFWD;
      8'h40:   return KIND_STOP;
      8'h50:   return KIND_STAT;
      default: return KIND_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous pins.
module spi_pin_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);
  logic [STAGES-1:0][N-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
`timescale 1ns/1ps
// Receive shifter: LSB-first, saturating bit counter one past the frame length.
module spi_rx_shift #(
  parameter int FRAME_W = 24,
  parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               sample_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] data_o,
  output logic [CNT_W-1:0]   count_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      count_o <= '0;
    end else if (start_i) begin
      data_o  <= '0;
      count_o <= '0;
    end else if (sample_i) begin
      data_o <= {bit_i, data_o[FRAME_W-1:1]};
      if (count_o != CNT_SAT) count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
// Transmit shifter: parallel load, LSB-first shift-out, zero fill.
module spi_tx_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_val_i,
  input  logic               shift_i,
  input  logic               clear_i,
  output logic               bit_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (clear_i) sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/spi_cmd_port.sv
`timescale 1ns/1ps
module spi_cmd_port
  import spi_cmd_pkg::*;
#(
  parameter int CTRL_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_ss_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              seq_eom,
  input  logic              seq_ovf,
  input  logic [ADDR_W-1:0] seq_row,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              cmd_exec,
  output logic [CTRL_W-1:0] cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [2:0]        cmd_kind,
  output logic              int_clr
);
  localparam int FRAME_W = CTRL_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int STAT_W  = ADDR_W + 2;

  // pin order: [0] select, [1] serial clock, [2] data in; select idles high
  logic [2:0] pins_s;
  logic       ss_prev_q, sclk_prev_q;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({spi_mosi, spi_sclk, spi_ss_n}),
    .sync_o (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      ss_prev_q   <= pins_s[0];
      sclk_prev_q <= pins_s[1];
    end
  end

  logic frame_open, frame_close, bit_sample, bit_advance;
  assign frame_open  =  ss_prev_q & ~pins_s[0];
  assign frame_close = ~ss_prev_q &  pins_s[0];
  assign bit_sample  = ~sclk_prev_q &  pins_s[1] & ~pins_s[0];
  assign bit_advance =  sclk_prev_q & ~pins_s[1] & ~pins_s[0];

  logic [FRAME_W-1:0] rx_data;
  logic [CNT_W-1:0]   rx_count;

  spi_rx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (frame_open),
    .sample_i (bit_sample),
    .bit_i    (pins_s[2]),
    .data_o   (rx_data),
    .count_o  (rx_count)
  );

  logic [FRAME_W-1:0] status_word;
  assign status_word = FRAME_W'({seq_row, seq_eom, seq_ovf});

  logic tx_bit;
  spi_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (frame_open),
    .load_val_i (status_word),
    .shift_i    (bit_advance),
    .clear_i    (frame_close),
    .bit_o      (tx_bit)
  );

  logic frame_ok;
  assign frame_ok = frame_close && (rx_count == CNT_W'(FRAME_W));

  logic oe_q, clr_q, exec_q;
  logic [CTRL_W-1:0] code_q;
  logic [ADDR_W-1:0] addr_q;
  cmd_kind_e         kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      clr_q  <= 1'b0;
      exec_q <= 1'b0;
      code_q <= '0;
      addr_q <= '0;
      kind_q <= KIND_NONE;
    end else begin
      clr_q  <= frame_open;
      exec_q <= frame_ok;
      if (frame_open)       oe_q <= 1'b1;
      else if (frame_close) oe_q <= 1'b0;
      if (frame_ok) begin
        code_q <= rx_data[FRAME_W-1 -: CTRL_W];
        addr_q <= rx_data[ADDR_W-1:0];
        kind_q <= decode_kind(8'(rx_data[FRAME_W-1 -: CTRL_W]));
      end
    end
  end

  assign spi_miso    = tx_bit;
  assign spi_miso_oe = oe_q;
  assign cmd_exec    = exec_q;
  assign cmd_code    = code_q;
  assign cmd_addr    = addr_q;
  assign cmd_kind    = kind_q;
  assign int_clr     = clr_q;

  initial begin
    if (FRAME_W < STAT_W) $error("frame too short for status word");
  end
endmodule

// File: rtl/spi_cmd_port_chk.sv
`timescale 1ns/1ps
module spi_cmd_port_chk #(
  parameter int CTRL_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              cmd_exec,
  input logic [CTRL_W-1:0] cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              int_clr
);
  a_r3_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr |=> !int_clr);

  a_r3_clr_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr |-> spi_miso_oe);

  a_r5_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_exec |=> !cmd_exec);

  a_r5_exec_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_exec |-> (!spi_miso_oe && $past(spi_miso_oe)));

  a_r4_fields_move_with_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cmd_code) || !$stable(cmd_addr)) |-> cmd_exec);

  a_r7_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);
endmodule

bind spi_cmd_port spi_cmd_port_chk #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .cmd_exec    (cmd_exec),
  .cmd_code    (cmd_code),
  .cmd_addr    (cmd_addr),
  .int_clr     (int_clr)
);

// File: tb/spi_cmd_port_test.sv
`timescale 1ns/1ps
module spi_cmd_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0, eom = 1'b0, ovf = 1'b0;
  logic [15:0] row = '0;
  logic miso, miso_oe, exec_o, clr_o;
  logic [7:0]  code_o;
  logic [15:0] addr_o;
  logic [2:0]  kind_o;

  spi_cmd_port uut (
    .clk(clk), .rst_n(rst_n), .spi_ss_n(ss_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .seq_eom(eom), .seq_ovf(ovf), .seq_row(row),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .cmd_exec(exec_o),
    .cmd_code(code_o), .cmd_addr(addr_o), .cmd_kind(kind_o), .int_clr(clr_o)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, exec_seen = 0, clr_seen = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] kind_of(input logic [7:0] c);
    if (c == 8'h10) return 3'd1;
    if (c == 8'h20) return 3'd2;
    if (c == 8'h30) return 3'd3;
    if (c == 8'h40) return 3'd4;
    if (c == 8'h50) return 3'd5;
    return 3'd0;
  endfunction

  // Reference model: pins seen through a three-sample delay (R9)
  logic [2:0] d1, d2, d3;
  logic m_miso, m_oe, m_exec, m_clr;
  logic [7:0] m_code;
  logic [15:0] m_addr;
  logic [2:0] m_kind;
  logic [23:0] txw;
  int tidx;
  bit rxq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 = 3'b001; d2 = 3'b001; d3 = 3'b001;
      m_miso = 0; m_oe = 0; m_exec = 0; m_clr = 0;
      m_code = 0; m_addr = 0; m_kind = 0; txw = 0; tidx = 0;
      rxq.delete();
    end else begin
      bit open_e, close_e, rise_e, fall_e;
      logic [23:0] w;
      open_e  = d3[0] && !d2[0];
      close_e = !d3[0] && d2[0];
      rise_e  = !d3[1] && d2[1] && !d2[0];
      fall_e  = d3[1] && !d2[1] && !d2[0];
      m_clr  = open_e;
      m_exec = 0;
      if (close_e && rxq.size() == 24) begin
        w = '0;
        for (int i = 0; i < 24; i++) w[i] = rxq[i];
        m_exec = 1; m_code = w[23:16]; m_addr = w[15:0]; m_kind = kind_of(w[23:16]);
      end
      if (rise_e) rxq.push_back(d2[2]);
      if (open_e) begin
        rxq.delete(); txw = {6'b0, row, eom, ovf}; tidx = 0; m_oe = 1;
      end
      if (fall_e) tidx++;
      if (close_e) m_oe = 0;
      m_miso = (m_oe && tidx < 24) ? txw[tidx] : 1'b0;
      d3 = d2; d2 = d1; d1 = {mosi, sclk, ss_n};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(miso === m_miso,    "R2/R9 miso",      miso,    m_miso);
      chk(miso_oe === m_oe,   "R7/R9 miso_oe",   miso_oe, m_oe);
      chk(clr_o === m_clr,    "R3/R9 int_clr",   clr_o,   m_clr);
      chk(exec_o === m_exec,  "R5/R9 cmd_exec",  exec_o,  m_exec);
      chk(code_o === m_code,  "R4 cmd_code",     code_o,  m_code);
      chk(addr_o === m_addr,  "R4 cmd_addr",     addr_o,  m_addr);
      chk(kind_o === m_kind,  "R8 cmd_kind",     kind_o,  m_kind);
      if (exec_o) exec_seen++;
      if (clr_o) clr_seen++;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits, input logic [7:0] code, input logic [15:0] addr);
    logic [23:0] cmdw, stw;
    logic [7:0]  old_code;
    logic [15:0] old_addr;
    logic [2:0]  old_kind;
    int e0, c0;
    cmdw = {code, addr};
    stw  = {6'b0, row, eom, ovf};
    old_code = code_o; old_addr = addr_o; old_kind = kind_o;
    e0 = exec_seen; c0 = clr_seen;
    @(negedge clk); ss_n = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? cmdw[i] : 1'b0;
      wait_clk(4);
      chk(miso === ((i < 24) ? stw[i] : 1'b0), "R2 status bit", miso, (i < 24) ? stw[i] : 1'b0);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    ss_n = 1'b1;
    wait_clk(8);
    chk(clr_seen - c0 == 1, "R3 one clear per frame", clr_seen - c0, 1);
    chk(!miso_oe, "R7 released after close", miso_oe, 0);
    if (nbits == 24) begin
      chk(exec_seen - e0 == 1, "R5 one strobe", exec_seen - e0, 1);
      chk(code_o === code, "R4 code captured", code_o, code);
      chk(addr_o === addr, "R4 addr captured", addr_o, addr);
      chk(kind_o === kind_of(code), "R8 kind decoded", kind_o, kind_of(code));
    end else begin
      chk(exec_seen - e0 == 0, "R6 no strobe", exec_seen - e0, 0);
      chk(code_o === old_code, "R6 code kept", code_o, old_code);
      chk(addr_o === old_addr, "R6 addr kept", addr_o, old_addr);
      chk(kind_o === old_kind, "R6 kind kept", kind_o, old_kind);
    end
  endtask

  initial begin
    wait_clk(3);
    // R10: outputs during reset
    chk({miso, miso_oe, exec_o, clr_o} === 4'b0, "R10 strobes in reset", {miso, miso_oe, exec_o, clr_o}, 0);
    chk(code_o === 8'h0 && addr_o === 16'h0 && kind_o === 3'd0, "R10 fields in reset", {code_o, addr_o}, 0);
    rst_n = 1'b1;
    wait_clk(4);

    row = 16'hBEEF; ovf = 1'b1; eom = 1'b0;
    run_frame(24, 8'h10, 16'h1234);
    row = 16'h8001; ovf = 1'b0; eom = 1'b1;
    run_frame(24, 8'h20, 16'hFFFF);
    row = 16'h5A5A; ovf = 1'b1; eom = 1'b1;
    run_frame(24, 8'h30, 16'h0001);
    run_frame(24, 8'h40, 16'h8000);
    row = 16'h0000; ovf = 1'b0; eom = 1'b0;
    run_frame(24, 8'h50, 16'h0F0F);
    run_frame(24, 8'h77, 16'hA5C3);
    // R6: short and long frames
    run_frame(10, 8'h20, 16'h4444);
    run_frame(23, 8'h30, 16'h3333);
    run_frame(30, 8'h40, 16'h2222);

    // R1: SCLK activity with select high
    begin
      int e0;
      e0 = exec_seen;
      for (int k = 0; k < 30; k++) begin
        mosi = k[0]; sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
        chk(!miso_oe && !miso, "R1 idle pins", {miso_oe, miso}, 0);
      end
      chk(exec_seen == e0, "R1 no strobe while idle", exec_seen - e0, 0);
      chk(code_o === 8'h77 && addr_o === 16'hA5C3, "R1 fields unchanged", {code_o, addr_o}, 24'h77A5C3);
    end
    // R1: a new frame restarts the count after a discarded one
    run_frame(24, 8'h10, 16'hC0DE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule